// File: doc/BRIEF.md
# Multithreaded Reorder Buffer with Squash Walk

This block keeps program order for a small set of hardware threads that share one pool of entries. The dispatch stage offers one instruction tag per cycle, with its thread number and a 16-bit sequence number. If the selected thread has room under the current sharing policy, the entry is appended to that thread's in-order queue, and the slot index it landed in is reported back. The execution side later marks that slot completed. Each thread retires from its own head, one entry per cycle, and only once the head entry is completed.

A misprediction or exception is handled with a squash request. The request names a thread and a sequence number. The block then walks that thread's queue backwards from its youngest entry. Each cycle it examines at most a parameterised number of entries, marks every entry that is younger than the given number as killed, and releases it. While the walk runs the thread takes no inserts and no retires. When the walk finishes, the tail is rewound and the thread's done flag returns high.

Occupancy is reported as a total free count, a free count per thread, and full and empty flags. The cap on a single thread's occupancy is chosen by a static policy input: unrestricted, an equal split among active threads, or a fixed percentage of the pool.

Top module: `rob_mt`

## Requirements
- R1: After a synchronous reset every queue is empty, `free_total` equals the pool size, `rob_empty` is 1, `rob_full` is 0, every `sq_done` bit and `all_sq_done` are 1, and every thread status reads idle.
- R2: `ins_ok` is high in the cycle that `ins_valid` is high only when all of these hold: the selected thread is active, it is not squashing, and its free count is nonzero. An accepted entry takes the slot shown on `ins_slot`, which starts at 0 after reset and advances by one, modulo the pool size, per accepted entry of that thread.
- R3: With `policy` = 0 (unrestricted), a thread's cap is the whole pool size.
- R4: With `policy` = 1 (equal split), a thread's cap is the pool size divided by the number of set bits in `thr_active`. An inactive thread never accepts an insert.
- R5: With `policy` = 2 (percentage), a thread's cap is pool size × PCT / 100, with integer division.
- R6: A thread's free count is the smaller of (cap − its occupancy, floored at 0) and `free_total`. `free_total` is the pool size minus the summed occupancy. `rob_full` is set when `free_total` is 0 and `rob_empty` when it equals the pool size. `thr_full` is set when occupancy ≥ cap, and `thr_empty` when occupancy is 0.
- R7: `ret_fire` for a thread is high only when `ret_req` is high, the queue is non-empty, the head entry has been marked completed through `cmp_valid`/`cmp_slot`, and the thread is not squashing. Each retire removes exactly one entry, and `head_seq` moves to the next entry.
- R8: A squash removes exactly the entries of the target thread whose sequence number s satisfies signed 16-bit (s − squash_seq) > 0, so the comparison stays correct across the 0xFFFF to 0x0000 wrap. Other threads are untouched, and the next insert reuses the first freed slot.
- R9: `sq_done` of the target thread drops in the cycle after the request. It rises again after max(1, ceil(E / SW)) walk cycles, where E is the number of killed entries plus one if an older entry remains in the queue.
- R10: `thr_status` per thread uses 2 bits: 0 = idle (empty), 1 = running (non-empty), 2 = squashing.
- R11: While a thread is squashing, and in the cycle its squash request is presented, it accepts no insert and fires no retire. A second squash request to a thread that is already squashing is ignored.
- R12: `all_sq_done` is the AND of all per-thread `sq_done` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| policy | input | 2 | Sharing policy: 0 unrestricted, 1 equal split, 2 percentage |
| thr_active | input | NT | Active thread mask |
| ins_valid | input | 1 | Insert request |
| ins_tid | input | TW | Insert thread |
| ins_seq | input | SEQW | Insert sequence number |
| ins_ok | output | 1 | Insert accepted this cycle |
| ins_slot | output | AW | Slot the insert takes |
| cmp_valid | input | 1 | Completion mark request |
| cmp_tid | input | TW | Completion thread |
| cmp_slot | input | AW | Completion slot |
| ret_req | input | NT | Per-thread retire request |
| ret_fire | output | NT | Per-thread retire performed |
| head_seq | output | NT*SEQW | Sequence number at each thread's head |
| sq_valid | input | 1 | Squash request |
| sq_tid | input | TW | Squash thread |
| sq_seq | input | SEQW | Squash boundary sequence number |
| free_total | output | CW | Free entries in the pool |
| thr_free | output | NT*CW | Per-thread free count |
| rob_full | output | 1 | Pool full |
| rob_empty | output | 1 | Pool empty |
| thr_full | output | NT | Thread at or above its cap |
| thr_empty | output | NT | Thread has no entries |
| sq_done | output | NT | Thread squash complete |
| all_sq_done | output | 1 | All threads squash complete |
| thr_status | output | NT*2 | Per-thread status code |

## Verification
The insert path is driven three ways: filling one thread past the pool size, filling both threads past a percentage cap through a table of vectors, and offering inserts to inactive threads under the equal split. Together these show whether the cap, the pool limit or the activity mask is the one rejecting an entry. The squash walk is run with an older survivor in the queue, on an empty queue, and across the sequence number wrap. The cycle count distinguishes a walk that stops early from one that runs out of entries, and the wrap case exposes an unsigned age compare. A retire is tried before completion, during a squash, and after both, which separates the completion gate from the squash gate.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    TS_IDLE = 2'd0,
    TS_RUN  = 2'd1,
    TS_SQ   = 2'd2
  } tstat_e;

  typedef enum logic [1:0] {
    SHR_DYN  = 2'd0,
    SHR_PART = 2'd1,
    SHR_THR  = 2'd2
  } share_e;
endpackage

// File: rtl/rob_tq.sv
// One thread's in-order queue with a multi-cycle backward squash walk.
// DEPTH must be a power of two so that the pointers wrap naturally.
module rob_tq
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int SW    = 2,
  parameter int SEQW  = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  logic [SEQW-1:0] push_seq,
  input  logic            cmpl,
  input  logic [AW-1:0]   cmpl_idx,
  input  logic            pop_req,
  input  logic            sq_start,
  input  logic [SEQW-1:0] sq_seq,
  output logic [CW-1:0]   cnt,
  output logic [AW-1:0]   tail_idx,
  output logic [SEQW-1:0] head_seq,
  output logic            pop_fire,
  output logic            busy,
  output logic            sq_done,
  output logic [1:0]      status
);
  logic [SEQW-1:0] seq_mem [DEPTH];
  logic [DEPTH-1:0] done_q, kill_q, kill_set;
  logic [AW-1:0]   head_q, tail_q, walk_q;
  logic [CW-1:0]   cnt_q, left_q, n_mark;
  logic [SEQW-1:0] sqseq_q;
  logic            sq_active_q, sq_done_q, stop, finish, sq_go, push_ok;

  assign sq_go   = sq_start && !sq_active_q;
  assign push_ok = push && !sq_active_q && !sq_start;
  assign pop_fire = pop_req && !sq_active_q && !sq_start && (cnt_q != '0)
                    && done_q[head_q] && !kill_q[head_q];

  // Backward walk: up to SW entries per cycle, stops at the first older one.
  always_comb begin
    n_mark   = '0;
    stop     = 1'b0;
    kill_set = '0;
    for (int j = 0; j < SW; j++) begin
      if (!stop && (CW'(j) < left_q)) begin
        if ($signed(SEQW'(seq_mem[walk_q - AW'(j)] - sqseq_q)) > 0) begin
          n_mark = n_mark + CW'(1);
          kill_set[walk_q - AW'(j)] = 1'b1;
        end else begin
          stop = 1'b1;
        end
      end
    end
    finish = sq_active_q && (stop || (left_q == n_mark));
  end

  always_ff @(posedge clk) begin
    if (push_ok) seq_mem[tail_q] <= push_seq;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q      <= '0;
      tail_q      <= '0;
      cnt_q       <= '0;
      walk_q      <= '0;
      left_q      <= '0;
      sqseq_q     <= '0;
      sq_active_q <= 1'b0;
      sq_done_q   <= 1'b1;
      done_q      <= '0;
      kill_q      <= '0;
    end else begin
      if (cmpl) done_q[cmpl_idx] <= 1'b1;
      if (sq_go) begin
        sq_active_q <= 1'b1;
        sq_done_q   <= 1'b0;
        sqseq_q     <= sq_seq;
        walk_q      <= tail_q - AW'(1);
        left_q      <= cnt_q;
      end else if (sq_active_q) begin
        walk_q <= walk_q - AW'(n_mark);
        left_q <= left_q - n_mark;
        cnt_q  <= cnt_q - n_mark;
        kill_q <= kill_q | kill_set;
        if (finish) begin
          sq_active_q <= 1'b0;
          sq_done_q   <= 1'b1;
          tail_q      <= walk_q - AW'(n_mark) + AW'(1);
        end
      end else begin
        if (push_ok) begin
          tail_q         <= tail_q + AW'(1);
          done_q[tail_q] <= 1'b0;
          kill_q[tail_q] <= 1'b0;
        end
        if (pop_fire) head_q <= head_q + AW'(1);
        cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_fire);
      end
    end
  end

  assign cnt      = cnt_q;
  assign tail_idx = tail_q;
  assign head_seq = seq_mem[head_q];
  assign busy     = sq_active_q;
  assign sq_done  = sq_done_q;
  assign status   = sq_active_q ? TS_SQ : ((cnt_q == '0) ? TS_IDLE : TS_RUN);

  // R11
  pop_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    sq_active_q |-> !pop_fire);
  // R9
  sq_clear_chk: assert property (@(posedge clk) disable iff (rst)
    sq_go |=> !sq_done_q);
  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH));
  // R7
  pop_count_chk: assert property (@(posedge clk) disable iff (rst)
    (pop_fire && !push_ok) |=> (cnt_q == $past(cnt_q) - CW'(1)));
endmodule

// File: rtl/rob_share.sv
// Per-thread cap from the sharing policy, plus pool and thread free counts.
module rob_share
  import rob_pkg::*;
#(
  parameter int NT  = 2,
  parameter int N   = 8,
  parameter int PCT = 50,
  localparam int CW = $clog2(N + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0]             policy,
  input  logic [NT-1:0]          active,
  input  logic [NT-1:0][CW-1:0]  cnt,
  output logic [CW-1:0]          free_total,
  output logic [NT-1:0][CW-1:0]  thr_free,
  output logic [NT-1:0]          thr_full
);
  logic [CW-1:0] cap, total;
  int            n_act;

  always_comb begin
    n_act = 0;
    for (int t = 0; t < NT; t++) n_act = n_act + int'(active[t]);
    case (share_e'(policy))
      SHR_PART: begin
        cap = '0;
        for (int k = 1; k <= NT; k++) if (n_act == k) cap = CW'(N / k);
      end
      SHR_THR: cap = CW'((N * PCT) / 100);
      default: cap = CW'(N);
    endcase
  end

  always_comb begin
    total = '0;
    for (int t = 0; t < NT; t++) total = total + cnt[t];
    free_total = CW'(N) - total;
  end

  generate
    for (genvar t = 0; t < NT; t++) begin : g_free
      logic [CW-1:0] room;
      assign room        = (cnt[t] >= cap) ? '0 : cap - cnt[t];
      assign thr_free[t] = (room > free_total) ? free_total : room;
      assign thr_full[t] = (cnt[t] >= cap);
    end
  endgenerate

  // R6
  free_bound_chk: assert property (@(posedge clk) disable iff (rst)
    free_total <= CW'(N));
endmodule

// File: rtl/rob_mt.sv
module rob_mt
  import rob_pkg::*;
#(
  parameter int NT   = 2,
  parameter int N    = 8,
  parameter int SW   = 2,
  parameter int SEQW = 16,
  parameter int PCT  = 50,
  localparam int TW  = (NT > 1) ? $clog2(NT) : 1,
  localparam int AW  = $clog2(N),
  localparam int CW  = $clog2(N + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         policy,
  input  logic [NT-1:0]      thr_active,
  input  logic               ins_valid,
  input  logic [TW-1:0]      ins_tid,
  input  logic [SEQW-1:0]    ins_seq,
  output logic               ins_ok,
  output logic [AW-1:0]      ins_slot,
  input  logic               cmp_valid,
  input  logic [TW-1:0]      cmp_tid,
  input  logic [AW-1:0]      cmp_slot,
  input  logic [NT-1:0]      ret_req,
  output logic [NT-1:0]      ret_fire,
  output logic [NT*SEQW-1:0] head_seq,
  input  logic               sq_valid,
  input  logic [TW-1:0]      sq_tid,
  input  logic [SEQW-1:0]    sq_seq,
  output logic [CW-1:0]      free_total,
  output logic [NT*CW-1:0]   thr_free,
  output logic               rob_full,
  output logic               rob_empty,
  output logic [NT-1:0]      thr_full,
  output logic [NT-1:0]      thr_empty,
  output logic [NT-1:0]      sq_done,
  output logic               all_sq_done,
  output logic [NT*2-1:0]    thr_status
);
  logic [NT-1:0][CW-1:0] cnt_w, free_w;
  logic [NT-1:0][AW-1:0] tail_w;
  logic [NT-1:0]         busy_w, hold_w;

  generate
    for (genvar t = 0; t < NT; t++) begin : g_thr
      assign hold_w[t] = busy_w[t] || (sq_valid && (int'(sq_tid) == t));
      rob_tq #(.DEPTH(N), .SW(SW), .SEQW(SEQW)) u_tq (
        .clk      (clk),
        .rst      (rst),
        .push     (ins_ok && (int'(ins_tid) == t)),
        .push_seq (ins_seq),
        .cmpl     (cmp_valid && (int'(cmp_tid) == t)),
        .cmpl_idx (cmp_slot),
        .pop_req  (ret_req[t]),
        .sq_start (sq_valid && (int'(sq_tid) == t)),
        .sq_seq   (sq_seq),
        .cnt      (cnt_w[t]),
        .tail_idx (tail_w[t]),
        .head_seq (head_seq[t*SEQW +: SEQW]),
        .pop_fire (ret_fire[t]),
        .busy     (busy_w[t]),
        .sq_done  (sq_done[t]),
        .status   (thr_status[t*2 +: 2])
      );
      assign thr_empty[t] = (cnt_w[t] == '0);
    end
  endgenerate

  rob_share #(.NT(NT), .N(N), .PCT(PCT)) u_share (
    .clk        (clk),
    .rst        (rst),
    .policy     (policy),
    .active     (thr_active),
    .cnt        (cnt_w),
    .free_total (free_total),
    .thr_free   (free_w),
    .thr_full   (thr_full)
  );

  assign thr_free    = free_w;
  assign ins_ok      = ins_valid && (int'(ins_tid) < NT) && thr_active[ins_tid]
                       && !hold_w[ins_tid] && (free_w[ins_tid] != '0);
  assign ins_slot    = tail_w[ins_tid];
  assign rob_full    = (free_total == '0);
  assign rob_empty   = (free_total == CW'(N));
  assign all_sq_done = &sq_done;

  // R2
  ins_room_chk: assert property (@(posedge clk) disable iff (rst)
    ins_ok |=> !rob_empty);
endmodule

// File: tb/rob_mt_bench.sv
`timescale 1ns/1ps
module rob_mt_bench;
  localparam int NT = 2, N = 8, SW = 2, SEQW = 16, PCT = 50;
  localparam int TW = 1, AW = 3, CW = 4;

  logic clk = 0, rst = 1;
  logic [1:0] policy = 0;
  logic [NT-1:0] thr_active = '1;
  logic ins_valid = 0; logic [TW-1:0] ins_tid = 0; logic [SEQW-1:0] ins_seq = 0;
  logic ins_ok; logic [AW-1:0] ins_slot;
  logic cmp_valid = 0; logic [TW-1:0] cmp_tid = 0; logic [AW-1:0] cmp_slot = 0;
  logic [NT-1:0] ret_req = 0, ret_fire;
  logic [NT*SEQW-1:0] head_seq;
  logic sq_valid = 0; logic [TW-1:0] sq_tid = 0; logic [SEQW-1:0] sq_seq = 0;
  logic [CW-1:0] free_total; logic [NT*CW-1:0] thr_free;
  logic rob_full, rob_empty, all_sq_done;
  logic [NT-1:0] thr_full, thr_empty, sq_done;
  logic [NT*2-1:0] thr_status;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic last_ok; logic [AW-1:0] last_slot; logic last_fire;

  always #5 clk = ~clk;

  rob_mt u_rob_mt (.*);

  // {tid, seq, expected accept} under the percentage policy, cap 4
  localparam logic [17:0] VEC [10] = '{
    {1'b0, 16'd1, 1'b1}, {1'b1, 16'd6, 1'b1}, {1'b0, 16'd2, 1'b1},
    {1'b0, 16'd3, 1'b1}, {1'b1, 16'd7, 1'b1}, {1'b0, 16'd4, 1'b1},
    {1'b0, 16'd5, 1'b0}, {1'b1, 16'd8, 1'b1}, {1'b1, 16'd9, 1'b1},
    {1'b1, 16'd10, 1'b0}};

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int tf(int t); return int'(thr_free[t*CW +: CW]); endfunction
  function automatic int hs(int t); return int'(head_seq[t*SEQW +: SEQW]); endfunction
  function automatic int st(int t); return int'(thr_status[t*2 +: 2]); endfunction

  task automatic do_reset(logic [1:0] pol, logic [NT-1:0] act);
    @(negedge clk); policy = pol; thr_active = act; rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  task automatic ins(int tid, int seq);
    @(negedge clk); ins_valid = 1; ins_tid = TW'(tid); ins_seq = SEQW'(seq);
    #1 last_ok = ins_ok; last_slot = ins_slot;
    @(posedge clk); #1 ins_valid = 0;
  endtask

  task automatic cmp(int tid, int slot);
    @(negedge clk); cmp_valid = 1; cmp_tid = TW'(tid); cmp_slot = AW'(slot);
    @(posedge clk); #1 cmp_valid = 0;
  endtask

  task automatic ret(int tid);
    @(negedge clk); ret_req = '0; ret_req[tid] = 1;
    #1 last_fire = ret_fire[tid];
    @(posedge clk); #1 ret_req = '0;
  endtask

  task automatic sq(int tid, int seq);
    @(negedge clk); sq_valid = 1; sq_tid = TW'(tid); sq_seq = SEQW'(seq);
    ins_valid = 1; ins_tid = TW'(tid); ins_seq = 16'h0777;
    #1 check("R11 insert blocked on squash request", int'(ins_ok), 0);
    @(posedge clk); #1 sq_valid = 0; ins_valid = 0;
  endtask

  task automatic wait_done(int tid, int start, int exp, string req);
    int cyc = start;
    while (!sq_done[tid] && cyc < 40) begin @(posedge clk); #1 cyc++; end
    check(req, cyc, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // Reset state
    do_reset(2'd0, 2'b11);
    @(negedge clk);
    check("R1 free_total", int'(free_total), N);
    check("R1 rob_empty", int'(rob_empty), 1);
    check("R1 rob_full", int'(rob_full), 0);
    check("R1 all_sq_done", int'(all_sq_done), 1);
    check("R1 status t0 idle", st(0), 0);
    check("R12 and of done", int'(sq_done), 3);

    // Unrestricted policy fill of one thread
    for (int i = 0; i < N; i++) begin
      ins(0, 100 + i);
      check("R2 accept", int'(last_ok), 1);
      check("R2 slot", int'(last_slot), i);
    end
    ins(1, 300);
    check("R3 pool exhausted reject", int'(last_ok), 0);
    @(negedge clk);
    check("R6 rob_full", int'(rob_full), 1);
    check("R3 t1 free", tf(1), 0);
    check("R6 t0 thr_full", int'(thr_full[0]), 1);
    check("R10 status running", st(0), 1);
    ret(0);
    check("R7 retire before completion", int'(last_fire), 0);
    cmp(0, 0);
    ret(0);
    check("R7 retire after completion", int'(last_fire), 1);
    @(negedge clk);
    check("R7 head advances", hs(0), 101);
    check("R7 one entry freed", int'(free_total), 1);

    // Percentage policy through the vector table
    do_reset(2'd2, 2'b11);
    foreach (VEC[i]) begin
      ins(int'(VEC[i][17]), int'(VEC[i][16:1]));
      check("R5 cap vector", int'(last_ok), int'(VEC[i][0]));
    end
    @(negedge clk);
    check("R5 pool full", int'(rob_full), 1);
    check("R6 both threads full", int'(thr_full), 3);

    // Equal split
    do_reset(2'd1, 2'b01);
    @(negedge clk);
    check("R4 single active cap", tf(0), 8);
    ins(1, 50);
    check("R4 inactive reject", int'(last_ok), 0);
    @(negedge clk); thr_active = 2'b11; #1;
    check("R4 two active cap", tf(0), 4);

    // Squash with an older survivor
    do_reset(2'd0, 2'b11);
    for (int i = 0; i < 6; i++) ins(0, 100 + i);
    ins(1, 200); ins(1, 201);
    cmp(0, 0);
    sq(0, 101);
    check("R9 done drops", int'(sq_done[0]), 0);
    check("R12 all done drops", int'(all_sq_done), 0);
    check("R10 status squashing", st(0), 2);
    ret(0);
    check("R11 retire blocked while squashing", int'(last_fire), 0);
    wait_done(0, 1, 3, "R9 walk cycles with survivor");
    @(negedge clk);
    check("R8 free_total after squash", int'(free_total), 4);
    check("R8 other thread untouched", hs(1), 200);
    check("R12 all done restored", int'(all_sq_done), 1);
    ret(0);
    check("R7 retire after squash", int'(last_fire), 1);
    @(negedge clk);
    check("R8 survivor at head", hs(0), 101);
    ins(0, 102);
    check("R8 tail rewound slot", int'(last_slot), 2);

    // Squash of an empty thread
    do_reset(2'd0, 2'b11);
    sq(1, 5);
    wait_done(1, 0, 1, "R9 empty walk one cycle");

    // Wrap-around sequence numbers
    do_reset(2'd0, 2'b11);
    ins(0, 16'hFFFE); ins(0, 16'hFFFF); ins(0, 16'h0000); ins(0, 16'h0001);
    sq(0, 16'hFFFF);
    wait_done(0, 0, 2, "R9 walk cycles across wrap");
    @(negedge clk);
    check("R8 wrap free_total", int'(free_total), 6);
    check("R8 wrap head", hs(0), 16'hFFFE);
    ins(0, 16'h0000);
    check("R8 wrap slot reuse", int'(last_slot), 2);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule